// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control sequencer of a battery-free nonvolatile SRAM. It decides when the SRAM array is copied into its nonvolatile shadow (a store) and when the shadow is copied back into the array (a recall). A transfer can be started by four things: the supply coming up, the supply dropping below its switch threshold, a falling edge on an active-low hardware store strobe, and single-cycle command pulses from a software sequence decoder. While a transfer runs, the block gates off SRAM access, holds a busy output high and runs a timer whose length is set per operation.

A write-seen flag records whether the array has been written since the last completed transfer. Stores started by supply loss or by the hardware strobe are skipped when this flag is clear. Software stores always run. Automatic store on supply loss can be switched off and on by command. When it is off, a supply loss only freezes access. All durations are parameters in clock cycles.

Top module: `nv_xfer_seq`

## Requirements
- R1: Once `supply_ok` is high after reset or after a supply loss, a recall runs for exactly PU_RECALL_CYC cycles with `busy` and `recall_act` high. `access_en` rises only after the recall ends.
- R2: When `supply_ok` goes low in the ready state, with auto-store enabled and the write-seen flag set, a store runs for exactly STORE_CYC cycles. After it, access stays off until the supply returns, and then R1 applies.
- R3: A store started by supply loss or by the hardware strobe is skipped (`busy` stays low) when no write has been accepted since the last completed transfer.
- R4: `access_en` is low whenever `busy` is high and within two cycles of `supply_ok` going low. A `mem_write` pulse while `access_en` is low does not set the write-seen flag.
- R5: A falling edge on `hw_store_n` in the ready state requests a store. While `access_pending` is high, the request waits and access stays enabled. The store starts once `access_pending` is low.
- R6: A `sw_store` pulse in the ready state always runs a store of STORE_CYC cycles with `store_act` high, whether or not a write has occurred.
- R7: A `sw_recall` pulse in the ready state runs a recall of exactly SW_RECALL_CYC cycles.
- R8: `auto_off` disables the automatic store, so that a supply loss only freezes access. `auto_on` enables it again. Auto-store is enabled out of reset.
- R9: The write-seen flag is cleared when any store or recall completes.
- R10: A trigger that arrives while `busy` is high is dropped. `busy` equals `store_act | recall_act`, and at most one of the two is high.
- R11: While `rst` is high, `busy`, `store_act`, `recall_act` and `access_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above switch threshold |
| hw_store_n | input | 1 | Active-low hardware store strobe |
| access_pending | input | 1 | An SRAM read or write is still in progress |
| mem_write | input | 1 | Pulse: a write was presented to the array |
| sw_store | input | 1 | Pulse: software store command |
| sw_recall | input | 1 | Pulse: software recall command |
| auto_off | input | 1 | Pulse: disable automatic store on supply loss |
| auto_on | input | 1 | Pulse: enable automatic store on supply loss |
| busy | output | 1 | A transfer is running |
| store_act | output | 1 | A store is running |
| recall_act | output | 1 | A recall is running |
| access_en | output | 1 | SRAM reads and writes are allowed |

## Verification
A table of scenarios pairs each trigger kind with a write beforehand or without one. Each scenario then counts the cycles `busy` is high. This separates a real transfer of the right length from a skipped one, and it separates a store from a recall by their durations. Supply-loss scenarios are run with auto-store enabled and disabled and with the write-seen flag set and clear. Each of them also times the recall that follows when the supply comes back. Directed cases then check three things: that writes while busy do not set the write-seen flag, that a command arriving during a recall is dropped rather than queued, and that a hardware strobe waits for a pending access.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_READY  = 2'd1,
    ST_STORE  = 2'd2,
    ST_RECALL = 2'd3
  } xfer_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nv_in_sync.sv
module nv_in_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_raw,
  input  logic hw_n_raw,
  output logic supply_q,
  output logic hw_fall
);
  logic [1:0] pipe [STAGES+1];
  logic       hw_prev;

  assign pipe[0] = {supply_raw, ~hw_n_raw};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g+1] <= 2'b00;
      else     pipe[g+1] <= pipe[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hw_prev <= 1'b0;
    else     hw_prev <= pipe[STAGES][0];
  end

  assign supply_q = pipe[STAGES][1];
  assign hw_fall  = pipe[STAGES][0] & ~hw_prev;
endmodule

// File: rtl/nv_op_timer.sv
module nv_op_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/nv_mode_flags.sv
module nv_mode_flags #(
  parameter bit AUTO_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_ok,
  input  logic auto_off,
  input  logic auto_on,
  input  logic wr_seen,
  input  logic clr_dirty,
  output logic auto_en,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (rst)                    auto_en <= AUTO_AT_RESET;
    else if (cmd_ok && auto_off) auto_en <= 1'b0;
    else if (cmd_ok && auto_on)  auto_en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            dirty <= 1'b0;
    else if (clr_dirty) dirty <= 1'b0;
    else if (wr_seen)   dirty <= 1'b1;
  end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nv_xfer_pkg::*;
#(
  parameter int PU_RECALL_CYC = 40,
  parameter int STORE_CYC     = 30,
  parameter int SW_RECALL_CYC = 12,
  parameter int SYNC_STAGES   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic hw_store_n,
  input  logic access_pending,
  input  logic mem_write,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic auto_off,
  input  logic auto_on,
  output logic busy,
  output logic store_act,
  output logic recall_act,
  output logic access_en
);
  localparam int MAX_CYC = max3(PU_RECALL_CYC, STORE_CYC, SW_RECALL_CYC);
  localparam int TW      = $clog2(MAX_CYC + 1);

  xfer_state_t   state, state_nxt;
  logic          sup_q, hw_fall;
  logic          hw_req, hw_take;
  logic          to_off, to_off_nxt;
  logic          tm_load, tm_done;
  logic [TW-1:0] tm_val;
  logic          auto_en, dirty, clr_dirty;
  logic          in_ready;

  nv_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .supply_raw(supply_ok), .hw_n_raw(hw_store_n),
    .supply_q(sup_q), .hw_fall(hw_fall)
  );

  nv_op_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  assign in_ready = (state == ST_READY);

  nv_mode_flags #(.AUTO_AT_RESET(1'b1)) u_flags (
    .clk(clk), .rst(rst), .cmd_ok(in_ready), .auto_off(auto_off),
    .auto_on(auto_on), .wr_seen(mem_write & access_en), .clr_dirty(clr_dirty),
    .auto_en(auto_en), .dirty(dirty)
  );

  always_comb begin
    state_nxt  = state;
    to_off_nxt = to_off;
    tm_load    = 1'b0;
    tm_val     = '0;
    clr_dirty  = 1'b0;
    hw_take    = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (sup_q) begin
          state_nxt = ST_RECALL;
          tm_load   = 1'b1;
          tm_val    = TW'(PU_RECALL_CYC - 1);
        end
      end
      ST_READY: begin
        if (!sup_q) begin
          if (auto_en && dirty) begin
            state_nxt  = ST_STORE;
            to_off_nxt = 1'b1;
            tm_load    = 1'b1;
            tm_val     = TW'(STORE_CYC - 1);
          end else begin
            state_nxt = ST_OFF;
          end
        end else if (hw_req && !access_pending) begin
          hw_take = 1'b1;
          if (dirty) begin
            state_nxt  = ST_STORE;
            to_off_nxt = 1'b0;
            tm_load    = 1'b1;
            tm_val     = TW'(STORE_CYC - 1);
          end
        end else if (sw_store) begin
          state_nxt  = ST_STORE;
          to_off_nxt = 1'b0;
          tm_load    = 1'b1;
          tm_val     = TW'(STORE_CYC - 1);
        end else if (sw_recall) begin
          state_nxt = ST_RECALL;
          tm_load   = 1'b1;
          tm_val    = TW'(SW_RECALL_CYC - 1);
        end
      end
      ST_STORE: begin
        if (tm_done) begin
          clr_dirty = 1'b1;
          state_nxt = to_off ? ST_OFF : ST_READY;
        end
      end
      ST_RECALL: begin
        if (tm_done) begin
          clr_dirty = 1'b1;
          state_nxt = ST_READY;
        end
      end
      default: state_nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OFF;
      to_off <= 1'b0;
      hw_req <= 1'b0;
    end else begin
      state  <= state_nxt;
      to_off <= to_off_nxt;
      if (!in_ready || hw_take) hw_req <= 1'b0;
      else if (hw_fall)         hw_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      store_act  <= 1'b0;
      recall_act <= 1'b0;
      access_en  <= 1'b0;
    end else begin
      busy       <= (state_nxt == ST_STORE) || (state_nxt == ST_RECALL);
      store_act  <= (state_nxt == ST_STORE);
      recall_act <= (state_nxt == ST_RECALL);
      access_en  <= (state_nxt == ST_READY) && sup_q;
    end
  end
endmodule

// File: rtl/nv_xfer_seq_chk.sv
module nv_xfer_seq_chk #(
  parameter int MAXC = 64
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic busy,
  input logic store_act,
  input logic recall_act,
  input logic access_en
);
  localparam int CW = $clog2(MAXC + 2) + 1;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_one_kind_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_act, recall_act}));

  assert_busy_kind_R10: assert property (@(posedge clk) disable iff (rst)
    busy == (store_act | recall_act));

  assert_no_access_busy_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !access_en);

  assert_freeze_low_supply_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!supply_ok, 2) |-> !access_en);

  assert_bounded_busy_R10: assert property (@(posedge clk) disable iff (rst)
    run_len <= CW'(MAXC));
endmodule

bind nv_xfer_seq nv_xfer_seq_chk #(
  .MAXC(nv_xfer_pkg::max3(PU_RECALL_CYC, STORE_CYC, SW_RECALL_CYC))
) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .busy(busy),
  .store_act(store_act), .recall_act(recall_act), .access_en(access_en)
);

// File: tb/nv_xfer_seq_tb.sv
module nv_xfer_seq_tb;
  localparam int PU = 40, ST = 30, SR = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1, hw_store_n = 1'b1, access_pending = 1'b0;
  logic mem_write = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
  logic auto_off = 1'b0, auto_on = 1'b0;
  logic busy, store_act, recall_act, access_en;
  int   nvec = 0, nfail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  nv_xfer_seq #(.PU_RECALL_CYC(PU), .STORE_CYC(ST), .SW_RECALL_CYC(SR)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .hw_store_n(hw_store_n),
    .access_pending(access_pending), .mem_write(mem_write), .sw_store(sw_store),
    .sw_recall(sw_recall), .auto_off(auto_off), .auto_on(auto_on),
    .busy(busy), .store_act(store_act), .recall_act(recall_act), .access_en(access_en)
  );

  // {kind, write-first, expected busy cycles}
  // kind: 0 hw strobe, 1 sw store, 2 sw recall, 3 supply loss,
  //       4 auto_off then supply loss, 5 auto_on then supply loss
  localparam logic [15:0] VEC [10] = '{
    16'h1_0_1E, 16'h0_0_00, 16'h0_1_1E, 16'h0_0_00, 16'h3_0_00,
    16'h3_1_1E, 16'h2_1_0C, 16'h0_0_00, 16'h4_1_00, 16'h5_1_1E
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    mem_write = 1'b0; sw_store = 1'b0; sw_recall = 1'b0;
    auto_off = 1'b0; auto_on = 1'b0; hw_store_n = 1'b1;
  endtask

  task automatic count_busy(input int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      clear_pulses();
      if (busy) n++;
    end
  endtask

  task automatic run_case(input int kind, input bit wr, input int exp, input string req);
    int n;
    if (wr) begin
      @(negedge clk) mem_write = 1'b1;
      @(negedge clk) mem_write = 1'b0;
    end
    if (kind == 4) begin
      @(negedge clk) auto_off = 1'b1;
      @(negedge clk) auto_off = 1'b0;
    end
    if (kind == 5) begin
      @(negedge clk) auto_on = 1'b1;
      @(negedge clk) auto_on = 1'b0;
    end
    @(negedge clk);
    case (kind)
      0: hw_store_n = 1'b0;
      1: sw_store = 1'b1;
      2: sw_recall = 1'b1;
      default: supply_ok = 1'b0;
    endcase
    count_busy(60, n);
    chk(n == exp, req, n, exp);
    if (kind >= 3) begin
      chk(access_en == 1'b0, "R4 frozen after supply loss", access_en, 0);
      supply_ok = 1'b1;
      count_busy(60, n);
      chk(n == PU, "R1 recall on supply return", n, PU);
      chk(access_en == 1'b1, "R1 access after recall", access_en, 1);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !store_act && !recall_act && !access_en, "R11 reset outputs",
        {busy, store_act, recall_act, access_en}, 0);
    rst = 1'b0;
    count_busy(60, n);
    chk(n == PU, "R1 power-up recall length", n, PU);
    chk(access_en == 1'b1, "R1 access after power-up recall", access_en, 1);

    for (int i = 0; i < 10; i++) begin
      string tag;
      case (VEC[i][15:12])
        4'd0: tag = (VEC[i][7:0] == 0) ? "R3 R9 hw skip" : "R5 hw store";
        4'd1: tag = "R6 sw store";
        4'd2: tag = "R7 sw recall";
        4'd3: tag = (VEC[i][7:0] == 0) ? "R3 auto skip" : "R2 auto store";
        4'd4: tag = "R8 auto disabled";
        default: tag = "R8 auto re-enabled";
      endcase
      run_case(int'(VEC[i][15:12]), VEC[i][8], int'(VEC[i][7:0]), tag);
    end

    // R4: write while busy is ignored; R6 store flag
    @(negedge clk) sw_store = 1'b1;
    @(negedge clk) sw_store = 1'b0; mem_write = 1'b1;
    chk(busy && store_act && !recall_act && !access_en, "R4 R6 store flags",
        {busy, store_act, recall_act, access_en}, 4'b1100);
    @(negedge clk) mem_write = 1'b0;
    repeat (40) @(negedge clk);
    run_case(0, 1'b0, 0, "R4 write during busy ignored");

    // R10: command during recall dropped
    n = 0;
    @(negedge clk) sw_recall = 1'b1;
    @(negedge clk) sw_recall = 1'b0; sw_store = 1'b1;
    chk(recall_act && !store_act, "R10 recall running", recall_act, 1);
    if (busy) n++;
    count_busy(58, n);
    n = n + 1;
    chk(n == SR, "R10 trigger dropped while busy", n, SR);

    // R5: hardware request waits for pending access
    access_pending = 1'b1;
    @(negedge clk) mem_write = 1'b1;
    @(negedge clk) mem_write = 1'b0; hw_store_n = 1'b0;
    count_busy(20, n);
    chk(n == 0, "R5 held while access pending", n, 0);
    chk(access_en == 1'b1, "R5 access kept while pending", access_en, 1);
    access_pending = 1'b0;
    count_busy(60, n);
    chk(n == ST, "R5 store after access ends", n, ST);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule